// File: doc/BRIEF.md
# Single-Cycle Montgomery Product Unit

This block multiplies two residues and folds the result back into operand width with Montgomery reduction. For each accepted beat it returns Z = A·B·2^-N mod M, where M is an odd N-bit modulus. The caller supplies A, B, the modulus M and the negated inverse Minv = −M^-1 mod 2^N with every beat. The modulus can therefore change from one beat to the next, and no tables are precomputed. Operands are expected to already be in the residue form, with A and B both below M. Mapping values into that form and back out, and producing Minv, are left to the caller.

The datapath uses three wide multiplications and no division. T = A·B is formed in full. Q is the low half of T0·Minv, and only the partial products of that half are built. S = Q·M is formed, and only its high half S1 is kept. The result is T1 + S1 plus a carry that is 1 exactly when T0 is non-zero. This replaces the addition of the two low halves, because their sum is always either zero or 2^N. One conditional subtraction of M brings the result below M. Each multiplier splits its operands into DIG_W-bit digits and sums the digit products.

Beats enter and leave over valid/ready handshakes. A beat is accepted on a rising edge where in_valid and in_ready are both high. Its result appears on out_z with out_valid on the following edge. in_ready is high whenever the output register is empty or is being drained in the same cycle. So with out_ready held high the unit accepts one beat per clock. While out_valid is high and out_ready is low, out_z and out_valid hold and in_ready stays low. A source must hold its beat stable until it is accepted.

Top module: `redinv_modmul`

## Requirements
- R1: A beat accepted at a clock edge produces out_valid = 1 on the next edge, with out_z·2^N ≡ A·B (mod M).
- R2: When the low N bits of A·B are all zero, out_z equals the high N bits of A·B. With A = 0 or B = 0 the result is 0, and with A = B = 2^(N/2) it is 1.
- R3: out_z is always strictly below the modulus of its beat, including for A = B = M−1.
- R4: While out_valid = 1 and out_ready = 0, in_ready is 0, and out_valid and out_z keep their values on every following edge until out_ready rises.
- R5: When a result is drained and a new beat is accepted at the same edge, the new result is valid on the next edge with no idle cycle. A drain with no new beat leaves out_valid = 0.
- R6: After reset, out_valid is 0 and in_ready is 1.
- R7: Each beat uses its own M and Minv, so consecutive beats with different odd moduli each yield the correct product for their own modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_a | input | N | Operand A, below M |
| in_b | input | N | Operand B, below M |
| in_mod | input | N | Odd modulus M, top bit set |
| in_minv | input | N | −M^-1 mod 2^N |
| out_valid | output | 1 | out_z holds a result |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_z | output | N | A·B·2^-N mod M |

## Verification
Draining a result and accepting a new beat can happen on the same edge. The bench provokes this in two ways. First, it streams two beats back to back with out_ready held high. Second, it stalls the output with a second beat waiting, then raises out_ready so that the drain and the accept land on one edge. In both cases the bench expects the second result on the very next edge and then an empty output register. Each result is judged arithmetically: out_z·2^N mod M must equal A·B mod M, and out_z must be below M. Where the value is known exactly, out_z is compared against it directly.

// File: rtl/redinv_pkg.sv
package redinv_pkg;
  localparam int MUL_FULL = 0;
  localparam int MUL_LOW  = 1;
  localparam int MUL_HIGH = 2;

  function automatic int mul_out_w(input int n, input int mode);
    return (mode == MUL_FULL) ? 2 * n : n;
  endfunction
endpackage

// File: rtl/redinv_digit_mul.sv
module redinv_digit_mul
  import redinv_pkg::*;
#(
  parameter int N     = 64,
  parameter int DIG_W = 16,
  parameter int MODE  = MUL_FULL,
  localparam int OW   = mul_out_w(N, MODE)
) (
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  output logic [OW-1:0] p
);
  localparam int ND = N / DIG_W;
  localparam int PW = 2 * N;

  logic [2*DIG_W-1:0] pp [ND*ND];
  logic [PW-1:0]      acc;

  for (genvar i = 0; i < ND; i++) begin : g_row
    for (genvar j = 0; j < ND; j++) begin : g_col
      if (MODE != MUL_LOW || (i + j) < ND) begin : g_pp
        assign pp[i*ND+j] = a[i*DIG_W +: DIG_W] * b[j*DIG_W +: DIG_W];
      end else begin : g_skip
        assign pp[i*ND+j] = '0;
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < ND; i++) begin
      for (int j = 0; j < ND; j++) begin
        acc = acc + (PW'(pp[i*ND+j]) << ((i + j) * DIG_W));
      end
    end
  end

  if (MODE == MUL_HIGH) begin : g_hi
    assign p = acc[PW-1 -: OW];
  end else begin : g_lo
    assign p = acc[OW-1:0];
  end
endmodule

// File: rtl/redinv_tail.sv
module redinv_tail #(
  parameter int N = 64
) (
  input  logic [N-1:0] t_hi,
  input  logic [N-1:0] t_lo,
  input  logic [N-1:0] s_hi,
  input  logic [N-1:0] m,
  output logic [N-1:0] z
);
  logic [N:0] sum;
  logic [N:0] diff;

  always_comb begin
    sum  = {1'b0, t_hi} + {1'b0, s_hi} + (N+1)'(|t_lo);
    diff = sum - {1'b0, m};
    z    = diff[N] ? sum[N-1:0] : diff[N-1:0];
  end
endmodule

// File: rtl/redinv_modmul.sv
module redinv_modmul
  import redinv_pkg::*;
#(
  parameter int N     = 64,
  parameter int DIG_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  input  logic [N-1:0] in_mod,
  input  logic [N-1:0] in_minv,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_z
);
  logic [2*N-1:0] t_full;
  logic [N-1:0]   q_lo;
  logic [N-1:0]   s_hi;
  logic [N-1:0]   z_next;
  logic           vld_q;
  logic [N-1:0]   z_q;
  logic           take;

  redinv_digit_mul #(.N(N), .DIG_W(DIG_W), .MODE(MUL_FULL)) u_mul_t (
    .a(in_a), .b(in_b), .p(t_full));

  redinv_digit_mul #(.N(N), .DIG_W(DIG_W), .MODE(MUL_LOW)) u_mul_q (
    .a(t_full[N-1:0]), .b(in_minv), .p(q_lo));

  redinv_digit_mul #(.N(N), .DIG_W(DIG_W), .MODE(MUL_HIGH)) u_mul_s (
    .a(q_lo), .b(in_mod), .p(s_hi));

  redinv_tail #(.N(N)) u_tail (
    .t_hi(t_full[2*N-1:N]), .t_lo(t_full[N-1:0]), .s_hi(s_hi),
    .m(in_mod), .z(z_next));

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      z_q   <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      z_q   <= z_next;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_z     = z_q;
endmodule

// File: rtl/redinv_modmul_chk.sv
module redinv_modmul_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] in_a,
  input logic [N-1:0] in_mod,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_z
);
  logic [N-1:0] held_mod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_mod <= '1;
    else if (in_valid && in_ready) held_mod <= in_mod;
  end

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R1

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_a == '0) |=> (out_z == '0)); // R2

  AST_BELOW_MODULUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_z < held_mod)); // R3

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_z))); // R4

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R5
endmodule

bind redinv_modmul redinv_modmul_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_mod(in_mod), .out_valid(out_valid),
  .out_ready(out_ready), .out_z(out_z));

// File: tb/redinv_modmul_tb.sv
`timescale 1ns/1ps
module redinv_modmul_tb;
  localparam int N = 64;
  localparam logic [N-1:0] M1 = 64'hF123_4567_89AB_CDEF;
  localparam logic [N-1:0] M2 = 64'hC000_0000_0000_0001;
  localparam logic [N-1:0] NOEXP = '1;
  // {a, b, m, exact expected or NOEXP}
  localparam logic [4*N-1:0] VEC [7] = '{
    {64'h0, 64'h1234_5678_9ABC_DEF0, M1, 64'h0},
    {64'h5, 64'h0, M2, 64'h0},
    {64'h1_0000_0000, 64'h1_0000_0000, M1, 64'h1},
    {64'h1_0000_0000, 64'h1_0000_0000, M2, 64'h1},
    {M1 - 64'h1, M1 - 64'h1, M1, NOEXP},
    {M2 - 64'h1, M2 - 64'h1, M2, NOEXP},
    {64'h0123_4567_89AB_CDEF, 64'hA5A5_5A5A_0F0F_F0F0, M1, NOEXP}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [N-1:0] in_a = '0, in_b = '0, in_mod = 64'h1, in_minv = '0;
  logic in_ready, out_valid;
  logic [N-1:0] out_z;
  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  redinv_modmul #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mod(in_mod), .in_minv(in_minv),
    .out_valid(out_valid), .out_ready(out_ready), .out_z(out_z));

  function automatic logic [N-1:0] neg_inv(input logic [N-1:0] m);
    logic [N-1:0] x;
    x = m;
    for (int k = 0; k < 6; k++) x = x * (64'h2 - m * x);
    return -x;
  endfunction

  task automatic bit_chk(input logic got, input logic exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic z_chk(input logic [N-1:0] a, input logic [N-1:0] b,
                       input logic [N-1:0] m, input logic [N-1:0] exact,
                       input string what);
    logic [2*N-1:0] lhs, rhs;
    lhs = {out_z, {N{1'b0}}} % {{N{1'b0}}, m};
    rhs = ({{N{1'b0}}, a} * {{N{1'b0}}, b}) % {{N{1'b0}}, m};
    n_cmp++;
    if (out_valid !== 1'b1 || lhs != rhs || out_z >= m ||
        (exact != NOEXP && out_z != exact)) begin
      n_bad++;
      $display("FAIL %s: got z=%h valid=%0b (z*R mod M=%h) expected A*B mod M=%h exact=%h",
               what, out_z, out_valid, lhs[N-1:0], rhs[N-1:0], exact);
    end
  endtask

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] m);
    in_valid = 1'b1; in_a = a; in_b = b; in_mod = m; in_minv = neg_inv(m);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [N-1:0] ra, rb, rm, xa, xb, xm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bit_chk(out_valid, 1'b0, "R6 out_valid after reset");
    bit_chk(in_ready, 1'b1, "R6 in_ready after reset");

    // Table walk, R1 R2 R3 R7
    for (int v = 0; v < 7; v++) begin
      drive(VEC[v][4*N-1 -: N], VEC[v][3*N-1 -: N], VEC[v][2*N-1 -: N]);
      @(negedge clk);
      in_valid = 1'b0;
      z_chk(VEC[v][4*N-1 -: N], VEC[v][3*N-1 -: N], VEC[v][2*N-1 -: N],
            VEC[v][N-1:0], $sformatf("R1/R2/R3 table entry %0d", v));
    end

    // Random odd moduli, each beat a new modulus: R7 R1 R3
    for (int r = 0; r < 200; r++) begin
      rm = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
      ra = {$urandom, $urandom} % rm;
      rb = (r % 10 == 0) ? rm - 64'h1 : {$urandom, $urandom} % rm;
      drive(ra, rb, rm);
      @(negedge clk);
      in_valid = 1'b0;
      z_chk(ra, rb, rm, NOEXP, "R7 random modulus");
    end

    // Back-to-back stream: R5
    @(negedge clk);
    drive(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, M1);
    @(negedge clk);
    z_chk(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, M1, NOEXP, "R5 first of pair");
    drive(64'h9, 64'h1_0000_0000_0000, M2);
    @(negedge clk);
    in_valid = 1'b0;
    z_chk(64'h9, 64'h1_0000_0000_0000, M2, NOEXP, "R5 second of pair, no bubble");
    @(negedge clk);
    bit_chk(out_valid, 1'b0, "R5 drained register empty");

    // Stall with a waiting beat, then drain and accept on one edge: R4 R5
    out_ready = 1'b0;
    xa = 64'h0F0F_0F0F_0F0F_0F0F; xb = 64'h3; xm = M1;
    drive(xa, xb, xm);
    @(negedge clk);
    z_chk(xa, xb, xm, NOEXP, "R4 stalled result");
    bit_chk(in_ready, 1'b0, "R4 in_ready low while stalled");
    drive(M2 - 64'h1, 64'h7, M2);
    repeat (3) @(negedge clk);
    z_chk(xa, xb, xm, NOEXP, "R4 result held across stall");
    bit_chk(in_ready, 1'b0, "R4 still not ready");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    z_chk(M2 - 64'h1, 64'h7, M2, NOEXP, "R5 drain and accept same edge");
    @(negedge clk);
    bit_chk(out_valid, 1'b0, "R5 empty after final drain");

    // Reset with a result pending: R6
    out_ready = 1'b0;
    drive(64'h2, 64'h3, M1);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bit_chk(out_valid, 1'b0, "R6 out_valid cleared by reset");
    bit_chk(in_ready, 1'b1, "R6 in_ready after mid-run reset");
    out_ready = 1'b1;

    done = 1'b1;
    summary();
  end
endmodule